// File: doc/BRIEF.md
# Preemptive Interrupt Priority Arbiter

This block decides which interrupt line a processor should take next. Each line contributes a pending flag, an enable flag and an 8-bit priority. A smaller priority number is more urgent. Only the upper `IMPL_BITS` bits of every priority are kept; the unimplemented low bits are forced to zero before any comparison. A runtime split setting divides the kept priority into two parts: the upper part is the preemption group and the lower part is the subpriority.

Among the lines that are both pending and enabled, the arbiter picks the one with the smallest kept priority. Because the group bits sit above the subpriority bits, this orders lines first by group and then by subpriority. When two lines are still equal, the lower index wins. The chosen line is then checked against three conditions. A global mask bit blocks everything. A base-priority threshold blocks any line whose group value is at or above it, and a threshold of zero blocks nothing. Finally, the line may nest only if its group is strictly more urgent than the group of the running handler. When no handler is running, the running level counts as one step beyond the least urgent value.

The decision is registered, so the outputs follow the inputs after one clock edge. The design has no state machine and only two conditions. Reset gives the idle condition, with no take request and zero outputs. Each clock edge then reloads the offer: either a take request with an index and a priority, or idle again.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Among pending, enabled lines, the line with the numerically lowest kept priority is offered, with no handler running and no masks set.
- R2: Priority bits below the top `IMPL_BITS` (bits 4:0 by default) are treated as zero, for both line priorities and the running priority. The reported priority carries zeros in those bits.
- R3: The split value `s` (0 to 7) makes bits 7:s+1 the preemption group and bits s:0 the subpriority. Within one group, the lower subpriority is offered first. With `s` = 7 every line is in the same group.
- R4: When kept priorities are equal, the lowest line index wins.
- R5: While a handler is running, a line is offered only if its group value is strictly below the running priority's group value. An equal group never nests, even when its subpriority is lower.
- R6: When no handler is running, any eligible line is offered, including one at priority 0xE0.
- R7: While `gmask_i` is 1, no line is offered.
- R8: A base threshold of zero (after clearing the unimplemented bits) masks nothing. A nonzero threshold blocks a line whose group value is greater than or equal to it.
- R9: A line that is pending but not enabled is never offered.
- R10: The outputs are registered with a latency of one clock. While `take_o` is 0, both `idx_o` and `prio_o` are 0. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NUM_IRQ | Pending flag, one bit per line |
| en_i | input | NUM_IRQ | Enable flag, one bit per line |
| prio_i | input | NUM_IRQ*8 | Priorities; line k uses bits 8k+7:8k |
| run_act_i | input | 1 | A handler is running |
| run_prio_i | input | 8 | Priority of the running handler |
| split_i | input | 3 | Bit position of the group/subpriority split |
| gmask_i | input | 1 | Global mask: blocks all lines |
| base_i | input | 8 | Base-priority threshold, 0 = off |
| take_o | output | 1 | Take request |
| idx_o | output | IDX_W | Index of the offered line |
| prio_o | output | 8 | Kept priority of the offered line |

## Verification
Three gates can act on the same winner in one cycle: the global mask, the base threshold and the nesting test against the running handler. The bench sets up cycles in which the winner passes the nesting test but one of the masks blocks it. It also sets up the opposite case, where the base threshold passes a line whose group clears the threshold while its full value would not. A take request is expected only when all three gates agree. The subpriority ordering and the equal-group no-nest rule are applied in the same cycle with the same split setting. This checks that the selection and the nesting decision use the same field boundary.

// File: rtl/pa_pkg.sv
package pa_pkg;

    localparam int PRIO_W = 8;

    // Keep-mask for the implemented (left-aligned) priority bits.
    function automatic logic [PRIO_W-1:0] impl_mask(input int unsigned bits);
        logic [PRIO_W-1:0] m;
        m = 8'hFF << (PRIO_W - bits);
        return m;
    endfunction

    // Mask selecting the preemption group: bits above the split position.
    function automatic logic [PRIO_W-1:0] grp_mask(input logic [2:0] split);
        logic [PRIO_W-1:0] t;
        t = 8'd2 << split;
        t = t - 8'd1;
        return ~t;
    endfunction

endpackage

// File: rtl/pa_line_key.sv
module pa_line_key
    import pa_pkg::*;
#(
    parameter int IMPL_BITS = 3
) (
    input  logic              pend,
    input  logic              en,
    input  logic [PRIO_W-1:0] prio_raw,
    output logic              valid,
    output logic [PRIO_W-1:0] key
);
    localparam logic [PRIO_W-1:0] KEEP = impl_mask(IMPL_BITS);

    always_comb begin
        valid = pend & en;
        key   = prio_raw & KEEP;
    end
endmodule

// File: rtl/pa_select.sv
module pa_select
    import pa_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_IRQ-1:0]             valid,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] key,
    output logic                           win_v,
    output logic [IDX_W-1:0]               win_idx,
    output logic [PRIO_W-1:0]              win_key
);
    always_comb begin
        win_v   = 1'b0;
        win_idx = '0;
        win_key = '1;
        // Strict compare keeps the earlier (lower) index on ties.
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (valid[i] && (!win_v || (key[i] < win_key))) begin
                win_v   = 1'b1;
                win_idx = IDX_W'(i);
                win_key = key[i];
            end
        end
    end
endmodule

// File: rtl/pa_gate.sv
module pa_gate
    import pa_pkg::*;
#(
    parameter int IMPL_BITS = 3
) (
    input  logic              win_v,
    input  logic [PRIO_W-1:0] win_key,
    input  logic              run_act,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic [2:0]        split,
    input  logic              gmask,
    input  logic [PRIO_W-1:0] base,
    output logic              take
);
    localparam logic [PRIO_W-1:0] KEEP = impl_mask(IMPL_BITS);

    logic [PRIO_W-1:0] gm;
    logic [PRIO_W:0]   win_grp;
    logic [PRIO_W:0]   run_grp;
    logic [PRIO_W-1:0] base_k;
    logic              base_blk;

    always_comb begin
        gm       = grp_mask(split);
        win_grp  = {1'b0, win_key & gm};
        // Idle: one level beyond the least urgent value.
        run_grp  = run_act ? {1'b0, run_prio & KEEP & gm} : {1'b1, {PRIO_W{1'b0}}};
        base_k   = base & KEEP;
        base_blk = (base_k != '0) && ((win_key & gm) >= base_k);
        take     = win_v && !gmask && !base_blk && (win_grp < run_grp);
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import pa_pkg::*;
#(
    parameter int NUM_IRQ   = 8,
    parameter int IMPL_BITS = 3,
    parameter int IDX_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ-1:0]        en_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic                      run_act_i,
    input  logic [PRIO_W-1:0]         run_prio_i,
    input  logic [2:0]                split_i,
    input  logic                      gmask_i,
    input  logic [PRIO_W-1:0]         base_i,
    output logic                      take_o,
    output logic [IDX_W-1:0]          idx_o,
    output logic [PRIO_W-1:0]         prio_o
);
    localparam logic [PRIO_W-1:0] KEEP = impl_mask(IMPL_BITS);

    logic [NUM_IRQ-1:0]             valid;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] key;
    logic                           win_v;
    logic [IDX_W-1:0]               win_idx;
    logic [PRIO_W-1:0]              win_key;
    logic                           take_d;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        pa_line_key #(.IMPL_BITS(IMPL_BITS)) u_key (
            .pend     (pend_i[g]),
            .en       (en_i[g]),
            .prio_raw (prio_i[g*PRIO_W +: PRIO_W]),
            .valid    (valid[g]),
            .key      (key[g])
        );
    end

    pa_select #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_sel (
        .valid   (valid),
        .key     (key),
        .win_v   (win_v),
        .win_idx (win_idx),
        .win_key (win_key)
    );

    pa_gate #(.IMPL_BITS(IMPL_BITS)) u_gate (
        .win_v    (win_v),
        .win_key  (win_key),
        .run_act  (run_act_i),
        .run_prio (run_prio_i),
        .split    (split_i),
        .gmask    (gmask_i),
        .base     (base_i),
        .take     (take_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_o <= 1'b0;
            idx_o  <= '0;
            prio_o <= '0;
        end else begin
            take_o <= take_d;
            idx_o  <= take_d ? win_idx : '0;
            prio_o <= take_d ? win_key : '0;
        end
    end

    // Shadow of eligibility used only by the checks below.
    logic [NUM_IRQ-1:0] elig_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) elig_q <= '0;
        else        elig_q <= pend_i & en_i;
    end

    assert_offer_eligible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> elig_q[idx_o]);

    assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((prio_o & ~KEEP) == '0));

    assert_gmask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gmask_i |=> !take_o);

    assert_nest_strict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_act_i |=> (!take_o ||
            ((prio_o & grp_mask($past(split_i))) <
             ($past(run_prio_i) & KEEP & grp_mask($past(split_i))))));

    assert_base_threshold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((base_i & KEEP) != '0) |=> (!take_o ||
            ((prio_o & grp_mask($past(split_i))) < ($past(base_i) & KEEP))));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (idx_o == '0 && prio_o == '0));

endmodule

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pend_i = '0, en_i = '0, run_prio_i = '0, base_i = '0;
    logic [63:0] prio_i = '0;
    logic        run_act_i = 1'b0, gmask_i = 1'b0;
    logic [2:0]  split_i = '0;
    logic        take_o;
    logic [2:0]  idx_o;
    logic [7:0]  prio_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_prio_arbiter u_irq_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .prio_i(prio_i),
        .run_act_i(run_act_i), .run_prio_i(run_prio_i), .split_i(split_i),
        .gmask_i(gmask_i), .base_i(base_i),
        .take_o(take_o), .idx_o(idx_o), .prio_o(prio_o)
    );

    typedef struct packed {
        logic [7:0]  pend;
        logic [7:0]  en;
        logic [63:0] prio;
        logic        act;
        logic [7:0]  runp;
        logic [2:0]  split;
        logic        gm;
        logic [7:0]  base;
        logic        xt;
        logic [2:0]  xi;
        logic [7:0]  xp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 19;
    // Line k priority is byte k of prio. rq gives the requirement number.
    localparam vec_t VEC [NV] = '{
        '{8'h0A, 8'hFF, 64'h0000_0000_4000_8000, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1, 3'd3, 8'h40, 4'd1},  // R1
        '{8'h03, 8'hFF, 64'h0000_0000_0000_4041, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1, 3'd0, 8'h40, 4'd2},  // R2
        '{8'h02, 8'hFF, 64'h0000_0000_0000_4000, 1'b1, 8'h5F, 3'd0, 1'b0, 8'h00, 1'b0, 3'd0, 8'h00, 4'd2},  // R2
        '{8'h24, 8'hFF, 64'h0000_4000_0060_0000, 1'b0, 8'h00, 3'd5, 1'b0, 8'h00, 1'b1, 3'd5, 8'h40, 4'd3},  // R3
        '{8'h01, 8'hFF, 64'h0000_0000_0000_0000, 1'b1, 8'hE0, 3'd7, 1'b0, 8'h00, 1'b0, 3'd0, 8'h00, 4'd3},  // R3
        '{8'h60, 8'hFF, 64'h00A0_A000_0000_0000, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1, 3'd5, 8'hA0, 4'd4},  // R4
        '{8'h10, 8'hFF, 64'h0000_0040_0000_0000, 1'b1, 8'h60, 3'd5, 1'b0, 8'h00, 1'b0, 3'd0, 8'h00, 4'd5},  // R5
        '{8'h10, 8'hFF, 64'h0000_0020_0000_0000, 1'b1, 8'h60, 3'd5, 1'b0, 8'h00, 1'b1, 3'd4, 8'h20, 4'd5},  // R5
        '{8'h02, 8'hFF, 64'h0000_0000_0000_4000, 1'b1, 8'h60, 3'd0, 1'b0, 8'h00, 1'b1, 3'd1, 8'h40, 4'd5},  // R5
        '{8'h02, 8'hFF, 64'h0000_0000_0000_6000, 1'b1, 8'h60, 3'd0, 1'b0, 8'h00, 1'b0, 3'd0, 8'h00, 4'd5},  // R5
        '{8'h80, 8'hFF, 64'hE000_0000_0000_0000, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1, 3'd7, 8'hE0, 4'd6},  // R6
        '{8'h01, 8'hFF, 64'h0000_0000_0000_0000, 1'b0, 8'h00, 3'd0, 1'b1, 8'h00, 1'b0, 3'd0, 8'h00, 4'd7},  // R7
        '{8'h08, 8'hFF, 64'h0000_0000_0000_0000, 1'b1, 8'hE0, 3'd0, 1'b1, 8'h00, 1'b0, 3'd0, 8'h00, 4'd7},  // R7
        '{8'h01, 8'hFF, 64'h0000_0000_0000_0000, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1, 3'd0, 8'h00, 4'd8},  // R8
        '{8'h04, 8'hFF, 64'h0000_0000_0060_0000, 1'b0, 8'h00, 3'd0, 1'b0, 8'h60, 1'b0, 3'd0, 8'h00, 4'd8},  // R8
        '{8'h04, 8'hFF, 64'h0000_0000_0040_0000, 1'b0, 8'h00, 3'd0, 1'b0, 8'h60, 1'b1, 3'd2, 8'h40, 4'd8},  // R8
        '{8'h04, 8'hFF, 64'h0000_0000_0060_0000, 1'b0, 8'h00, 3'd5, 1'b0, 8'h60, 1'b1, 3'd2, 8'h60, 4'd8},  // R8
        '{8'h01, 8'hFE, 64'h0000_0000_0000_0000, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 3'd0, 8'h00, 4'd9},  // R9
        '{8'h03, 8'h02, 64'h0000_0000_0000_C000, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1, 3'd1, 8'hC0, 4'd9}   // R9
    };

    task automatic check(input string tag, input logic et, input logic [2:0] ei, input logic [7:0] ep);
        checks++;
        if (take_o !== et || idx_o !== ei || prio_o !== ep) begin
            failures++;
            $display("FAIL %s: got take=%0b idx=%0d prio=%02h, expected take=%0b idx=%0d prio=%02h",
                     tag, take_o, idx_o, prio_o, et, ei, ep);
        end
    endtask

    task automatic drive(input vec_t v);
        pend_i = v.pend; en_i = v.en; prio_i = v.prio; run_act_i = v.act;
        run_prio_i = v.runp; split_i = v.split; gmask_i = v.gm; base_i = v.base;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R10: reset holds outputs at zero even with an eligible line.
        pend_i = 8'h01; en_i = 8'hFF;
        repeat (3) @(negedge clk);
        check("R10 reset state", 1'b0, 3'd0, 8'h00);
        rst_n = 1'b1;
        pend_i = '0;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VEC[k]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[k].rq, k), VEC[k].xt, VEC[k].xi, VEC[k].xp);
        end

        // R10: one-cycle latency; output holds until the next edge.
        @(negedge clk);
        drive(VEC[10]);
        @(negedge clk);
        pend_i = '0;
        #4;
        check("R10 holds before edge", 1'b1, 3'd7, 8'hE0);
        @(negedge clk);
        check("R10 idle after edge", 1'b0, 3'd0, 8'h00);

        // R7 + R5 in one cycle: nest-capable line released when mask drops.
        @(negedge clk);
        pend_i = 8'h08; en_i = 8'hFF; prio_i = 64'h0; run_act_i = 1'b1;
        run_prio_i = 8'hA0; split_i = 3'd0; gmask_i = 1'b1; base_i = 8'h00;
        @(negedge clk);
        check("R7 mask over nest", 1'b0, 3'd0, 8'h00);
        gmask_i = 1'b0;
        @(negedge clk);
        check("R5 nest after unmask", 1'b1, 3'd3, 8'h00);

        // R8 + R5: threshold blocks a line that would nest.
        base_i = 8'h40; prio_i = 64'h0000_0000_4000_0000;
        @(negedge clk);
        check("R8 threshold over nest", 1'b0, 3'd0, 8'h00);

        // R4 with R3: ties in group and sub across split 5, lowest index.
        base_i = 8'h00; run_act_i = 1'b0; split_i = 3'd5; pend_i = 8'h81;
        prio_i = 64'h4000_0000_0000_0040;
        @(negedge clk);
        check("R4 tie lowest index", 1'b1, 3'd0, 8'h40);

        done = 1;
        finish_run();
    end
endmodule